// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block supplies the word address for each beat of a four-beat burst into a synchronous memory. On a load cycle it captures a full external address. On each following advance cycle it keeps the upper address bits fixed and steps the two low bits through a four-beat order that depends on the starting value. After four beats the order wraps back to the start and repeats.

Two orders are supported. In interleaved order the low bits are the start bits XORed with a beat count. In linear order they are the start bits plus the beat count, modulo four. The order is chosen by a pin that is sampled on the load cycle, so it stays fixed for the whole burst.

An active-low clock enable freezes the block completely. A device-select input gates loads only: a load-type cycle with the device not selected leaves the address unchanged. Advance cycles keep the burst going whether or not the device is selected.

Top module: `burst_addr_gen`

## Requirements
- R1: After a synchronous reset, `word_addr` is all zeros.
- R2: When `clk_en_n`=0, `step_nload`=0 and `dev_sel`=1 at a rising edge, `word_addr` equals `addr_in` after that edge.
- R3: When `order_ilv`=1 at load, the low two bits of `word_addr` follow start XOR beat on successive advances. Start 00 gives 00,01,10,11; start 01 gives 01,00,11,10; start 10 gives 10,11,00,01; start 11 gives 11,10,01,00.
- R4: After the fourth beat the low bits return to the start value, and the same sequence repeats on further advances.
- R5: An advance (`clk_en_n`=0, `step_nload`=1) never changes `word_addr` bits above bit 1.
- R6: When `order_ilv`=0 at load, the low bits on beat b are (start + b) mod 4. For example, start 01 gives 01,10,11,00.
- R7: An edge with `clk_en_n`=1 leaves `word_addr` unchanged, whatever the other inputs are.
- R8: An edge with `clk_en_n`=0, `step_nload`=0 and `dev_sel`=0 leaves `word_addr` unchanged.
- R9: Changing `order_ilv` during a burst has no effect until the next load.
- R10: A load in the middle of a burst restarts the beat count, so the new start address is beat 0 of its own sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes all state |
| step_nload | input | 1 | High: advance the beat; low: load `addr_in` |
| dev_sel | input | 1 | Device selected; a load needs it high |
| order_ilv | input | 1 | Burst order sampled at load: 1 interleaved, 0 linear |
| addr_in | input | ADDR_W | External start address |
| word_addr | output | ADDR_W | Current burst word address |

## Verification
The assertions check the edge-local rules on every cycle: reset clears the address, a selected load copies the input, a frozen or deselected edge holds the address, and an advance keeps the upper bits while moving the low bits. Only the bench scenarios can show the full orders across a burst. These are the exact four-beat sequences for every start value in both orders, the wrap and repetition after the fourth beat, the order pin being latched at load, and a mid-burst reload restarting the count.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } bag_op_e;

endpackage

// File: rtl/bag_ctl_decode.sv
module bag_ctl_decode
    import burst_addr_pkg::*;
(
    input  logic    clk_en_n,
    input  logic    step_nload,
    input  logic    dev_sel,
    output bag_op_e op
);
    always_comb begin
        op = OP_HOLD;
        if (!clk_en_n) begin
            if (step_nload) begin
                op = OP_STEP;
            end else if (dev_sel) begin
                op = OP_LOAD;
            end
        end
    end
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  logic              ilv,
    output logic [BEAT_W-1:0] lo
);
    logic [BEAT_W-1:0] xr;
    logic [BEAT_W-1:0] lin;

    for (genvar i = 0; i < BEAT_W; i++) begin : g_xor
        assign xr[i] = start[i] ^ beat[i];
    end

    assign lin = start + beat;
    assign lo  = ilv ? xr : lin;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              step_nload,
    input  logic              dev_sel,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] word_addr
);
    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] beat;
        logic              ilv;
    } st_t;

    st_t               st_d;
    st_t               st_q;
    bag_op_e           op;
    logic [BEAT_W-1:0] lo;

    bag_ctl_decode u_dec (
        .clk_en_n   (clk_en_n),
        .step_nload (step_nload),
        .dev_sel    (dev_sel),
        .op         (op)
    );

    always_comb begin
        st_d = st_q;
        case (op)
            OP_LOAD: begin
                st_d.hi    = addr_in[ADDR_W-1:BEAT_W];
                st_d.start = addr_in[BEAT_W-1:0];
                st_d.beat  = '0;
                st_d.ilv   = order_ilv;
            end
            OP_STEP: begin
                st_d.beat = st_q.beat + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    bag_order_map #(.BEAT_W(BEAT_W)) u_map (
        .start (st_q.start),
        .beat  (st_q.beat),
        .ilv   (st_q.ilv),
        .lo    (lo)
    );

    assign word_addr = {st_q.hi, lo};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en_n,
    input logic              step_nload,
    input logic              dev_sel,
    input logic              order_ilv,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] word_addr
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (word_addr == '0));

    // R2
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !step_nload && dev_sel) |=> (word_addr == $past(addr_in)));

    // R7
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> $stable(word_addr));

    // R8
    desel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !step_nload && !dev_sel) |=> $stable(word_addr));

    // R5
    upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && step_nload) |=> $stable(word_addr[ADDR_W-1:BEAT_W]));

    // R3
    step_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && step_nload) |=> (word_addr[BEAT_W-1:0] != $past(word_addr[BEAT_W-1:0])));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en_n = 1'b0;
    logic          step_nload = 1'b0;
    logic          dev_sel = 1'b0;
    logic          order_ilv = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] word_addr;

    int total = 0;
    int fails = 0;

    logic [AW-3:0] m_hi = '0;
    logic [1:0]    m_start = '0;
    logic [1:0]    m_beat = '0;
    logic          m_ilv = 1'b0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) uut (
        .clk        (clk),
        .rst        (rst),
        .clk_en_n   (clk_en_n),
        .step_nload (step_nload),
        .dev_sel    (dev_sel),
        .order_ilv  (order_ilv),
        .addr_in    (addr_in),
        .word_addr  (word_addr)
    );

    function automatic logic [AW-1:0] expect_addr();
        logic [1:0] lo;
        lo = m_ilv ? (m_start ^ m_beat) : 2'((m_start + m_beat) & 2'b11);
        return {m_hi, lo};
    endfunction

    task automatic chk(input string tag, input logic [AW-1:0] exp);
        total++;
        if (word_addr !== exp) begin
            fails++;
            $display("FAIL %s: word_addr=%h expected=%h", tag, word_addr, exp);
        end
    endtask

    // Drive one cycle and update the reference model from the requirements.
    task automatic cyc(input logic ce_n, input logic adv, input logic sel,
                       input logic ilv, input logic [AW-1:0] a);
        @(negedge clk);
        clk_en_n   = ce_n;
        step_nload = adv;
        dev_sel    = sel;
        order_ilv  = ilv;
        addr_in    = a;
        @(posedge clk);
        #1;
        if (!ce_n) begin
            if (!adv && sel) begin
                m_hi = a[AW-1:2]; m_start = a[1:0]; m_beat = '0; m_ilv = ilv;
            end else if (adv) begin
                m_beat = m_beat + 1'b1;
            end
        end
    endtask

    initial begin
        #800000;
        total++; fails++;
        $display("FAIL watchdog: word_addr=%h expected=finish", word_addr);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        logic [AW-1:0] held;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset", '0);
        @(negedge clk);
        rst = 1'b0;

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                a = {15'(16'h1357 * (s + 1) + m * 16'h0F0F), 2'(s)};
                cyc(1'b0, 1'b0, 1'b1, 1'(m), a);
                chk("R2 load", a);
                for (int b = 1; b <= 8; b++) begin
                    // order pin toggled mid-burst must not matter (R9)
                    cyc(1'b0, 1'b1, 1'b0, 1'(~m), ~a);
                    chk(b > 4 ? "R4 wrap" : (m != 0 ? "R3 interleaved R5 R9" : "R6 linear R5 R9"),
                        expect_addr());
                    // explicit wrap check: beat 4 returns to start
                    if (b == 4) chk("R4 return", a);
                    if (b == 2) begin
                        held = word_addr;
                        cyc(1'b1, 1'b0, 1'b1, 1'(~m), ~a);
                        chk("R7 freeze", held);
                        cyc(1'b1, 1'b1, 1'b0, 1'(m), a);
                        chk("R7 freeze step", held);
                        cyc(1'b0, 1'b0, 1'b0, 1'(~m), ~a);
                        chk("R8 deselect", held);
                    end
                end
            end
        end

        // explicit stated orders, interleaved start 01 and linear start 01
        a = {15'h2AAA, 2'b01};
        cyc(1'b0, 1'b0, 1'b1, 1'b1, a);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, a);
        chk("R3 01->00", {15'h2AAA, 2'b00});
        cyc(1'b0, 1'b1, 1'b1, 1'b1, a);
        chk("R3 01->11", {15'h2AAA, 2'b11});
        cyc(1'b0, 1'b1, 1'b1, 1'b1, a);
        chk("R3 01->10", {15'h2AAA, 2'b10});
        cyc(1'b0, 1'b0, 1'b1, 1'b0, a);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, a);
        chk("R6 01->10", {15'h2AAA, 2'b10});
        cyc(1'b0, 1'b1, 1'b1, 1'b0, a);
        chk("R6 10->11", {15'h2AAA, 2'b11});

        // mid-burst reload restarts the beat count
        a = {15'h1234, 2'b10};
        cyc(1'b0, 1'b0, 1'b1, 1'b1, a);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, a);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, a);
        chk("R10 reload", a);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, a);
        chk("R10 first step", {15'h1234, 2'b11});

        // reset during a burst
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 reset mid-burst", '0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule